// File: doc/BRIEF.md
# Contiguous-Region Translation Cache

This block is a small fully-associative translation cache that sits beside a page-table walker. It stores leaf translations, each tagged with the address space identifier that was current when the walk started. A lookup presents a virtual page number and an address space identifier in one cycle. The result (hit, physical page number and the eight flag bits of the cached page-table entry) appears registered on the next cycle.

An entry can be marked as covering a naturally aligned 64 KiB contiguous region, which is sixteen 4 KiB pages. Such an entry is filled once. It then matches every page of its region, because the low four bits of the page number are left out of the tag compare. On such a hit, the low four bits of the returned physical page number are taken from the lookup page number, so one entry does the work of sixteen.

Fills come from the walker and are placed round-robin. Before a fill is written, every entry whose coverage would overlap it is dropped, so a lookup never matches more than one entry. A flush input clears the whole cache in one cycle, or only the non-global entries of one address space. The block does not check permissions. It returns the stored flags, including a clear valid bit, so that the consumer can raise the fault.

Top module: `contig_tlb`

## Requirements
- R1: After reset no entry is valid, `rsp_hit_o` is low, and a lookup misses.
- R2: The result of a lookup appears on the outputs on the clock edge after the cycle in which `lookup_req_i` is high. `rsp_hit_o` is low after any cycle with no request.
- R3: A lookup hits only a valid entry whose page-number tag equals the lookup page number under the entry's mask. The entry must also be global (flag bit 5 set) or carry the lookup's address space identifier.
- R4: An entry filled with `fill_napot_i` high ignores page-number bits 3:0 in the compare, so it matches all sixteen pages of its aligned region and no page outside it.
- R5: On a hit of a region entry, `rsp_ppn_o[3:0]` equals the lookup page number bits 3:0, and the upper bits come from the stored physical page number. On a hit of a normal entry, all bits come from the stored value.
- R6: `rsp_flags_o` returns the eight stored flag bits unchanged. A fill whose valid flag (bit 0) is clear is stored and reported as a hit with bit 0 low.
- R7: A fill invalidates every entry that could match a page the new entry matches. At most one entry hits any lookup.
- R8: Fills go to slots in round-robin order, with the pointer advancing by one per fill. After eight further distinct fills, the ninth overwrites the oldest of them.
- R9: `flush_i` with `flush_asid_en_i` low clears every entry in one cycle.
- R10: `flush_i` with `flush_asid_en_i` high clears only the non-global entries tagged with `flush_asid_i`. Global entries and entries of other address spaces stay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_req_i | input | 1 | Lookup request |
| lookup_vpn_i | input | VPN_W | Virtual page number to translate |
| lookup_asid_i | input | ASID_W | Address space of the lookup |
| fill_i | input | 1 | Write a new translation |
| fill_vpn_i | input | VPN_W | Virtual page number of the fill |
| fill_asid_i | input | ASID_W | Address space in effect at walk start |
| fill_ppn_i | input | PPN_W | Physical page number of the fill |
| fill_flags_i | input | 8 | Page-table entry flag bits (bit 0 valid, bit 5 global) |
| fill_napot_i | input | 1 | Fill covers an aligned 64 KiB region |
| flush_i | input | 1 | Flush request |
| flush_asid_en_i | input | 1 | Restrict flush to one address space |
| flush_asid_i | input | ASID_W | Address space to flush |
| rsp_hit_o | output | 1 | Registered hit |
| rsp_ppn_o | output | PPN_W | Registered physical page number |
| rsp_flags_o | output | 8 | Registered flag bits |

## Verification
The bench builds the block with its default parameters: eight entries, a 27-bit page number, a 44-bit physical page number, a 16-bit address space identifier and a four-bit region mask. With eight entries, a run of nine distinct fills is enough to wrap the replacement pointer and observe the eviction of the oldest slot. The 27-bit page number leaves room for region edges on both sides of a 64 KiB block, and for lookups that differ from a tag only in masked or unmasked bits.

// File: rtl/contig_tlb_pkg.sv
package contig_tlb_pkg;
  localparam int unsigned FLAG_W = 8;
  localparam int unsigned FLAG_V = 0;
  localparam int unsigned FLAG_G = 5;
  typedef logic [FLAG_W-1:0] flags_t;
endpackage

// File: rtl/contig_tlb_entry.sv
module contig_tlb_entry
  import contig_tlb_pkg::*;
#(
  parameter int unsigned VPN_W      = 27,
  parameter int unsigned PPN_W      = 44,
  parameter int unsigned ASID_W     = 16,
  parameter int unsigned NAPOT_BITS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_i,
  input  logic              wr_sel_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  flags_t            fill_flags_i,
  input  logic              fill_napot_i,
  input  logic              flush_i,
  input  logic              flush_asid_en_i,
  input  logic [ASID_W-1:0] flush_asid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              hit_o,
  output logic              valid_o,
  output logic              napot_o,
  output logic [PPN_W-1:0]  ppn_o,
  output flags_t            flags_o
);
  localparam int unsigned HI_W = VPN_W - NAPOT_BITS;
  localparam logic [VPN_W-1:0] FULL_MASK   = {VPN_W{1'b1}};
  localparam logic [VPN_W-1:0] REGION_MASK = {{HI_W{1'b1}}, {NAPOT_BITS{1'b0}}};

  logic              valid_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;
  logic [PPN_W-1:0]  ppn_q;
  flags_t            flags_q;
  logic              napot_q;

  logic             glob;
  logic [VPN_W-1:0] lk_mask, ov_mask;
  logic             lk_match, overlap, flush_hit;

  assign glob    = flags_q[FLAG_G];
  assign lk_mask = napot_q ? REGION_MASK : FULL_MASK;
  // union of both coverages: any shared page means overlap
  assign ov_mask = (napot_q || fill_napot_i) ? REGION_MASK : FULL_MASK;

  assign lk_match = (((lk_vpn_i ^ vpn_q) & lk_mask) == '0);
  assign hit_o    = valid_q && lk_match && (glob || (asid_q == lk_asid_i));

  assign overlap = valid_q && (((fill_vpn_i ^ vpn_q) & ov_mask) == '0) &&
                   (glob || fill_flags_i[FLAG_G] || (asid_q == fill_asid_i));

  assign flush_hit = flush_i &&
                     (!flush_asid_en_i || (!glob && (asid_q == flush_asid_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vpn_q   <= '0;
      asid_q  <= '0;
      ppn_q   <= '0;
      flags_q <= '0;
      napot_q <= 1'b0;
    end else begin
      if (flush_hit) valid_q <= 1'b0;
      if (fill_i && overlap) valid_q <= 1'b0;
      if (fill_i && wr_sel_i) begin
        valid_q <= 1'b1;
        vpn_q   <= fill_vpn_i;
        asid_q  <= fill_asid_i;
        ppn_q   <= fill_ppn_i;
        flags_q <= fill_flags_i;
        napot_q <= fill_napot_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign napot_o = napot_q;
  assign ppn_o   = ppn_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/contig_tlb_victim.sv
module contig_tlb_victim #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  output logic [ENTRIES-1:0] sel_o,
  output logic [IDX_W-1:0]   ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_sel
    assign sel_o[g] = (ptr_q == IDX_W'(g));
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/contig_tlb_resp.sv
module contig_tlb_resp
  import contig_tlb_pkg::*;
#(
  parameter int unsigned ENTRIES    = 8,
  parameter int unsigned PPN_W      = 44,
  parameter int unsigned NAPOT_BITS = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic [ENTRIES-1:0]            hit_vec_i,
  input  logic [ENTRIES-1:0]            napot_vec_i,
  input  logic [ENTRIES-1:0][PPN_W-1:0] ppn_arr_i,
  input  flags_t [ENTRIES-1:0]          flags_arr_i,
  input  logic [NAPOT_BITS-1:0]         vpn_lo_i,
  output logic                          hit_o,
  output logic [PPN_W-1:0]              ppn_o,
  output flags_t                        flags_o
);
  logic [PPN_W-1:0] sel_ppn, out_ppn;
  flags_t           sel_flags;
  logic             sel_napot;

  // hits are one-hot, so an OR tree is the mux
  always_comb begin
    sel_ppn   = '0;
    sel_flags = '0;
    sel_napot = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec_i[i]) begin
        sel_ppn   = sel_ppn | ppn_arr_i[i];
        sel_flags = sel_flags | flags_arr_i[i];
        sel_napot = sel_napot | napot_vec_i[i];
      end
    end
  end

  assign out_ppn = {sel_ppn[PPN_W-1:NAPOT_BITS],
                    sel_napot ? vpn_lo_i : sel_ppn[NAPOT_BITS-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o   <= 1'b0;
      ppn_o   <= '0;
      flags_o <= '0;
    end else begin
      hit_o   <= req_i && (|hit_vec_i);
      ppn_o   <= out_ppn;
      flags_o <= sel_flags;
    end
  end
endmodule

// File: rtl/contig_tlb.sv
module contig_tlb
  import contig_tlb_pkg::*;
#(
  parameter int unsigned ENTRIES    = 8,
  parameter int unsigned VPN_W      = 27,
  parameter int unsigned PPN_W      = 44,
  parameter int unsigned ASID_W     = 16,
  parameter int unsigned NAPOT_BITS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_req_i,
  input  logic [VPN_W-1:0]  lookup_vpn_i,
  input  logic [ASID_W-1:0] lookup_asid_i,
  input  logic              fill_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [7:0]        fill_flags_i,
  input  logic              fill_napot_i,
  input  logic              flush_i,
  input  logic              flush_asid_en_i,
  input  logic [ASID_W-1:0] flush_asid_i,
  output logic              rsp_hit_o,
  output logic [PPN_W-1:0]  rsp_ppn_o,
  output logic [7:0]        rsp_flags_o
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            hit_vec, valid_vec, napot_vec, wr_sel;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_arr;
  flags_t [ENTRIES-1:0]          flags_arr;
  logic [IDX_W-1:0]              victim_ptr;
  flags_t                        rsp_flags;

  contig_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (fill_i),
    .sel_o (wr_sel),
    .ptr_o (victim_ptr)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    contig_tlb_entry #(
      .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W), .NAPOT_BITS(NAPOT_BITS)
    ) u_ent (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .fill_i         (fill_i),
      .wr_sel_i       (wr_sel[g]),
      .fill_vpn_i     (fill_vpn_i),
      .fill_asid_i    (fill_asid_i),
      .fill_ppn_i     (fill_ppn_i),
      .fill_flags_i   (fill_flags_i),
      .fill_napot_i   (fill_napot_i),
      .flush_i        (flush_i),
      .flush_asid_en_i(flush_asid_en_i),
      .flush_asid_i   (flush_asid_i),
      .lk_vpn_i       (lookup_vpn_i),
      .lk_asid_i      (lookup_asid_i),
      .hit_o          (hit_vec[g]),
      .valid_o        (valid_vec[g]),
      .napot_o        (napot_vec[g]),
      .ppn_o          (ppn_arr[g]),
      .flags_o        (flags_arr[g])
    );
  end

  contig_tlb_resp #(
    .ENTRIES(ENTRIES), .PPN_W(PPN_W), .NAPOT_BITS(NAPOT_BITS)
  ) u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (lookup_req_i),
    .hit_vec_i  (hit_vec),
    .napot_vec_i(napot_vec),
    .ppn_arr_i  (ppn_arr),
    .flags_arr_i(flags_arr),
    .vpn_lo_i   (lookup_vpn_i[NAPOT_BITS-1:0]),
    .hit_o      (rsp_hit_o),
    .ppn_o      (rsp_ppn_o),
    .flags_o    (rsp_flags)
  );

  assign rsp_flags_o = rsp_flags;
endmodule

// File: rtl/contig_tlb_chk.sv
module contig_tlb_chk #(
  parameter int unsigned ENTRIES    = 8,
  parameter int unsigned PPN_W      = 44,
  parameter int unsigned NAPOT_BITS = 4,
  parameter int unsigned IDX_W      = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  lookup_req_i,
  input logic [NAPOT_BITS-1:0] vpn_lo_i,
  input logic                  fill_i,
  input logic                  flush_i,
  input logic                  flush_asid_en_i,
  input logic [ENTRIES-1:0]    hit_vec_i,
  input logic [ENTRIES-1:0]    valid_vec_i,
  input logic [ENTRIES-1:0]    napot_vec_i,
  input logic [IDX_W-1:0]      victim_ptr_i,
  input logic                  rsp_hit_o,
  input logic [PPN_W-1:0]      rsp_ppn_o
);
  a_r1_reset_empty: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (valid_vec_i == '0) && !rsp_hit_o);

  a_r7_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_i));

  a_r2_idle_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_req_i |=> !rsp_hit_o);

  a_r2_hit_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_req_i && (|hit_vec_i)) |=> rsp_hit_o);

  a_r5_region_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_req_i && (|(hit_vec_i & napot_vec_i))) |=>
      (rsp_ppn_o[NAPOT_BITS-1:0] == $past(vpn_lo_i)));

  a_r9_flush_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !flush_asid_en_i && !fill_i) |=> (valid_vec_i == '0));

  a_r8_ptr_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> (victim_ptr_i != $past(victim_ptr_i)));

  a_r8_ptr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_i |=> $stable(victim_ptr_i));

  a_r8_fill_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> (|valid_vec_i));
endmodule

bind contig_tlb contig_tlb_chk #(
  .ENTRIES(ENTRIES), .PPN_W(PPN_W), .NAPOT_BITS(NAPOT_BITS), .IDX_W(IDX_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lookup_req_i   (lookup_req_i),
  .vpn_lo_i       (lookup_vpn_i[NAPOT_BITS-1:0]),
  .fill_i         (fill_i),
  .flush_i        (flush_i),
  .flush_asid_en_i(flush_asid_en_i),
  .hit_vec_i      (hit_vec),
  .valid_vec_i    (valid_vec),
  .napot_vec_i    (napot_vec),
  .victim_ptr_i   (victim_ptr),
  .rsp_hit_o      (rsp_hit_o),
  .rsp_ppn_o      (rsp_ppn_o)
);

// File: tb/contig_tlb_test.sv
module contig_tlb_test;
  localparam int unsigned VPN_W = 27, PPN_W = 44, ASID_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lookup_req = 1'b0;
  logic [VPN_W-1:0]  lookup_vpn = '0;
  logic [ASID_W-1:0] lookup_asid = '0;
  logic              fill = 1'b0;
  logic [VPN_W-1:0]  fill_vpn = '0;
  logic [ASID_W-1:0] fill_asid = '0;
  logic [PPN_W-1:0]  fill_ppn = '0;
  logic [7:0]        fill_flags = '0;
  logic              fill_napot = 1'b0;
  logic              flush = 1'b0;
  logic              flush_asid_en = 1'b0;
  logic [ASID_W-1:0] flush_asid = '0;
  logic              rsp_hit;
  logic [PPN_W-1:0]  rsp_ppn;
  logic [7:0]        rsp_flags;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  contig_tlb uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lookup_req_i(lookup_req), .lookup_vpn_i(lookup_vpn), .lookup_asid_i(lookup_asid),
    .fill_i(fill), .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid),
    .fill_ppn_i(fill_ppn), .fill_flags_i(fill_flags), .fill_napot_i(fill_napot),
    .flush_i(flush), .flush_asid_en_i(flush_asid_en), .flush_asid_i(flush_asid),
    .rsp_hit_o(rsp_hit), .rsp_ppn_o(rsp_ppn), .rsp_flags_o(rsp_flags)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                         input logic [PPN_W-1:0] p, input logic [7:0] f, input logic nap);
    @(negedge clk);
    fill = 1'b1; fill_vpn = v; fill_asid = a; fill_ppn = p; fill_flags = f; fill_napot = nap;
    @(negedge clk);
    fill = 1'b0;
  endtask

  task automatic do_lookup(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
    @(negedge clk);
    lookup_req = 1'b1; lookup_vpn = v; lookup_asid = a;
    @(negedge clk);
    lookup_req = 1'b0;
  endtask

  task automatic do_flush(input logic by_asid, input logic [ASID_W-1:0] a);
    @(negedge clk);
    flush = 1'b1; flush_asid_en = by_asid; flush_asid = a;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic expect_hit(input string tag, input logic [VPN_W-1:0] v,
                            input logic [ASID_W-1:0] a, input logic [PPN_W-1:0] p,
                            input logic [7:0] f);
    do_lookup(v, a);
    chk({tag, " hit"}, 64'(rsp_hit), 64'd1);
    chk({tag, " ppn"}, 64'(rsp_ppn), 64'(p));
    chk({tag, " flags"}, 64'(rsp_flags), 64'(f));
  endtask

  task automatic expect_miss(input string tag, input logic [VPN_W-1:0] v,
                             input logic [ASID_W-1:0] a);
    do_lookup(v, a);
    chk({tag, " miss"}, 64'(rsp_hit), 64'd0);
  endtask

  function automatic logic [PPN_W-1:0] region_ppn(input logic [PPN_W-1:0] p,
                                                  input logic [VPN_W-1:0] v);
    return {p[PPN_W-1:4], v[3:0]};
  endfunction

  task automatic t_reset();
    chk("R1 reset hit", 64'(rsp_hit), 64'd0);
    expect_miss("R1 empty", 27'h0, 16'h0);
  endtask

  task automatic t_basic();
    do_fill(27'h12_3456, 16'd1, 44'h0AB_CDEF_0123, 8'hC3, 1'b0);
    expect_hit("R3 exact", 27'h12_3456, 16'd1, 44'h0AB_CDEF_0123, 8'hC3);
    @(negedge clk);
    chk("R2 idle after hit", 64'(rsp_hit), 64'd0);
    expect_miss("R3 other asid", 27'h12_3456, 16'd2);
    expect_miss("R3 neighbour page", 27'h12_3457, 16'd1);
    expect_miss("R3 low bits differ", 27'h12_3450, 16'd1);
  endtask

  task automatic t_region();
    do_fill(27'h0A_0035, 16'd1, 44'h000_0777_7125, 8'hC3, 1'b1);
    expect_hit("R4 R5 region low edge", 27'h0A_0030, 16'd1,
               region_ppn(44'h000_0777_7125, 27'h0A_0030), 8'hC3);
    expect_hit("R4 R5 region high edge", 27'h0A_003F, 16'd1,
               region_ppn(44'h000_0777_7125, 27'h0A_003F), 8'hC3);
    expect_hit("R4 R5 region middle", 27'h0A_0037, 16'd1,
               region_ppn(44'h000_0777_7125, 27'h0A_0037), 8'hC3);
    expect_miss("R4 above region", 27'h0A_0040, 16'd1);
    expect_miss("R4 below region", 27'h0A_002F, 16'd1);
  endtask

  task automatic t_global();
    do_fill(27'h1F_0000, 16'd3, 44'h000_0000_4444, 8'hE1, 1'b0);
    expect_hit("R3 global any asid", 27'h1F_0000, 16'd9, 44'h000_0000_4444, 8'hE1);
  endtask

  task automatic t_vclear();
    do_fill(27'h05_5500, 16'd1, 44'h000_0000_0999, 8'h02, 1'b0);
    expect_hit("R6 invalid pte stored", 27'h05_5500, 16'd1, 44'h000_0000_0999, 8'h02);
  endtask

  task automatic t_overlap();
    do_fill(27'h0A_0033, 16'd1, 44'h000_0000_0123, 8'hC3, 1'b0);
    expect_miss("R7 region dropped", 27'h0A_0037, 16'd1);
    expect_hit("R7 small replaces region", 27'h0A_0033, 16'd1, 44'h000_0000_0123, 8'hC3);
    do_fill(27'h05_5505, 16'd1, 44'h000_0000_8880, 8'hC7, 1'b1);
    expect_hit("R7 region replaces small", 27'h05_5500, 16'd1,
               region_ppn(44'h000_0000_8880, 27'h05_5500), 8'hC7);
  endtask

  task automatic t_flush_asid();
    do_fill(27'h02_2222, 16'd2, 44'h000_0000_2222, 8'hC3, 1'b0);
    do_flush(1'b1, 16'd1);
    expect_miss("R10 asid1 entry cleared", 27'h12_3456, 16'd1);
    expect_miss("R10 asid1 small cleared", 27'h0A_0033, 16'd1);
    expect_hit("R10 global kept", 27'h1F_0000, 16'd1, 44'h000_0000_4444, 8'hE1);
    expect_hit("R10 asid2 kept", 27'h02_2222, 16'd2, 44'h000_0000_2222, 8'hC3);
  endtask

  task automatic t_flush_all();
    do_flush(1'b0, 16'd0);
    expect_miss("R9 global cleared", 27'h1F_0000, 16'd3);
    expect_miss("R9 asid2 cleared", 27'h02_2222, 16'd2);
  endtask

  task automatic t_round_robin();
    for (int k = 0; k < 9; k++)
      do_fill(27'h30_0000 | 27'(k << 8), 16'd4, 44'h500 + 44'(k), 8'hC3, 1'b0);
    expect_miss("R8 oldest evicted", 27'h30_0000, 16'd4);
    for (int k = 1; k < 9; k++)
      expect_hit("R8 younger kept", 27'h30_0000 | 27'(k << 8), 16'd4,
                 44'h500 + 44'(k), 8'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_region();
    t_global();
    t_vclear();
    t_overlap();
    t_flush_asid();
    t_flush_all();
    t_round_robin();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all act=running exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule